// File: doc/BRIEF.md
# Masked Lockstep Processing Element Array

The block is a two-dimensional grid of identical integer processing elements that all obey one shared instruction per clock. A control unit places an opcode, two register selectors, a global address and a scalar data word on the inputs. On the next rising edge every element carries out that instruction on its own private state. Each element holds four general-purpose registers, one index register, one local-address register and a mask flag.

While an element's mask flag is set, the shared instruction has no effect on its registers. Only the two mask-control instructions still run in such an element, so a masked element can be reloaded or released. The mask flag therefore gives each element a small amount of private control inside a strictly lockstep machine.

Each element adds its own index register to the shared global address, so the same instruction points every element at a different local address. Arithmetic is two's-complement and wraps. Neighbour data movement, instruction fetch and memory live outside this block.

Top module: `simd_pe_array`

## Requirements
- R1: After a synchronous active-high reset, every general-purpose register, index register, local-address register and mask flag of every element reads zero.
- R2: Opcode 1 (broadcast) writes `cu_data_i` into register `rd_i` of every unmasked element.
- R3: Opcode 2 (add) sets register `rd_i` to `rd_i + rs_i`, modulo 2^DW, in every unmasked element.
- R4: Opcode 3 (subtract) sets register `rd_i` to `rd_i - rs_i`, modulo 2^DW, in every unmasked element.
- R5: For any opcode other than 7 and 8, an element whose mask flag was set when the instruction was issued keeps all its registers, its index and its local address unchanged.
- R6: Opcode 7 (set mask) loads each element's mask flag from bit DW-1 (the sign bit) of its own register `rs_i`. This happens in masked elements too.
- R7: Opcode 8 (clear mask) clears the mask flag of every element.
- R8: Opcode 5 loads the index register from register `rs_i`. Opcode 6 sets the local-address register to (index + `gaddr_i`) modulo 2^AW. Both act in unmasked elements only.
- R9: Opcode 4 writes the element's linear position, row*COLS + col, into register `rd_i` of every unmasked element.
- R10: Opcode 0 (no-operation) and the reserved opcodes 9 to 15 change no state in any element.
- R11: Every effect of an instruction shows on the outputs from the clock edge that captures it, one cycle after issue. All elements update on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Issued opcode, 0 = no-operation |
| rd_i | input | 2 | Destination register selector |
| rs_i | input | 2 | Source register selector |
| gaddr_i | input | AW | Global address carried by the instruction |
| cu_data_i | input | DW | Control unit scalar data word |
| gpr_o | output | ROWS*COLS*4*DW | All registers; element p, register r at bits [(p*4+r)*DW +: DW] |
| mask_o | output | ROWS*COLS | Mask flag of element p at bit p |
| addr_o | output | ROWS*COLS*AW | Local address of element p at bits [p*AW +: AW] |

## Verification
Every result of this block is due exactly one rising edge after the instruction is presented. The effects include register writes, mask changes, index loads and local-address updates. The bench drives each instruction on a falling edge and updates its model at the next rising edge. It compares the full state of all sixteen elements at the following falling edge, before any new instruction can take effect. Masked elements are checked against their previous value in the same compare, because the mask the model uses is the one held at the moment of issue.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int NREG  = 4;
  localparam int SEL_W = 2;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_BCAST   = 4'd1,
    OP_ADD     = 4'd2,
    OP_SUB     = 4'd3,
    OP_LDID    = 4'd4,
    OP_SETIDX  = 4'd5,
    OP_LADR    = 4'd6,
    OP_SETMASK = 4'd7,
    OP_CLRMASK = 4'd8
  } op_e;
endpackage

// File: rtl/simd_pe_alu.sv
module simd_pe_alu
  import simd_pkg::*;
#(
  parameter int DW = 16,
  parameter int ID = 0
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [DW-1:0]   cu_data_i,
  output logic [DW-1:0]   res_o,
  output logic            we_o
);
  always_comb begin
    res_o = '0;
    we_o  = 1'b0;
    case (op_i)
      OP_BCAST: begin res_o = cu_data_i; we_o = 1'b1; end
      OP_ADD:   begin res_o = a_i + b_i; we_o = 1'b1; end
      OP_SUB:   begin res_o = a_i - b_i; we_o = 1'b1; end
      OP_LDID:  begin res_o = DW'(ID);   we_o = 1'b1; end
      default:  begin res_o = '0;        we_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    op_i,
  input  logic [SEL_W-1:0]   rd_i,
  input  logic [SEL_W-1:0]   rs_i,
  input  logic [AW-1:0]      gaddr_i,
  input  logic [DW-1:0]      cu_data_i,
  output logic [NREG*DW-1:0] gpr_o,
  output logic [DW-1:0]      idx_o,
  output logic               mask_o,
  output logic [AW-1:0]      addr_o
);
  logic [DW-1:0] gpr [NREG];
  logic [DW-1:0] opa, opb, alu_res;
  logic          alu_we;

  assign opa = gpr[rd_i];
  assign opb = gpr[rs_i];

  simd_pe_alu #(.DW(DW), .ID(ID)) u_alu (
    .op_i      (op_i),
    .a_i       (opa),
    .b_i       (opb),
    .cu_data_i (cu_data_i),
    .res_o     (alu_res),
    .we_o      (alu_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) gpr[r] <= '0;
      idx_o  <= '0;
      mask_o <= 1'b0;
      addr_o <= '0;
    end else begin
      if (op_i == OP_SETMASK)      mask_o <= opb[DW-1];
      else if (op_i == OP_CLRMASK) mask_o <= 1'b0;
      if (!mask_o) begin
        if (alu_we)               gpr[rd_i] <= alu_res;
        if (op_i == OP_SETIDX)    idx_o     <= opb;
        if (op_i == OP_LADR)      addr_o    <= AW'(idx_o) + gaddr_i;
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_out
    assign gpr_o[r*DW +: DW] = gpr[r];
  end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 16,
  parameter int AW   = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [3:0]                    op_i,
  input  logic [1:0]                    rd_i,
  input  logic [1:0]                    rs_i,
  input  logic [AW-1:0]                 gaddr_i,
  input  logic [DW-1:0]                 cu_data_i,
  output logic [ROWS*COLS*NREG*DW-1:0]  gpr_o,
  output logic [ROWS*COLS-1:0]          mask_o,
  output logic [ROWS*COLS*AW-1:0]       addr_o
);
  localparam int NPE  = ROWS * COLS;
  localparam int PE_W = NREG * DW;

  logic [NPE*DW-1:0] idx_flat;

  for (genvar row = 0; row < ROWS; row++) begin : g_row
    for (genvar col = 0; col < COLS; col++) begin : g_col
      localparam int P = row * COLS + col;
      simd_pe #(.DW(DW), .AW(AW), .ID(P)) u_pe (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .rd_i      (rd_i),
        .rs_i      (rs_i),
        .gaddr_i   (gaddr_i),
        .cu_data_i (cu_data_i),
        .gpr_o     (gpr_o[P*PE_W +: PE_W]),
        .idx_o     (idx_flat[P*DW +: DW]),
        .mask_o    (mask_o[P]),
        .addr_o    (addr_o[P*AW +: AW])
      );
    end
  end
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk
  import simd_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DW   = 16,
  parameter int AW   = 12
) (
  input logic                         clk,
  input logic                         rst,
  input logic [3:0]                   op_i,
  input logic [1:0]                   rd_i,
  input logic [AW-1:0]                gaddr_i,
  input logic [DW-1:0]                cu_data_i,
  input logic [ROWS*COLS*NREG*DW-1:0] gpr_o,
  input logic [ROWS*COLS-1:0]         mask_o,
  input logic [ROWS*COLS*AW-1:0]      addr_o,
  input logic [ROWS*COLS*DW-1:0]      idx_flat
);
  localparam int NPE  = ROWS * COLS;
  localparam int PE_W = NREG * DW;

  p_clear_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CLRMASK) |=> (mask_o == '0));

  p_nop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOP) |=> ($stable(gpr_o) && $stable(mask_o) && $stable(addr_o)));

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    p_masked_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (mask_o[p] && op_i != OP_SETMASK && op_i != OP_CLRMASK)
      |=> ($stable(gpr_o[p*PE_W +: PE_W]) && $stable(addr_o[p*AW +: AW])
           && $stable(idx_flat[p*DW +: DW])));

    p_local_addr_r8: assert property (@(posedge clk) disable iff (rst)
      (!mask_o[p] && op_i == OP_LADR)
      |=> (addr_o[p*AW +: AW] == $past(AW'(idx_flat[p*DW +: DW]) + gaddr_i)));

    for (genvar r = 0; r < NREG; r++) begin : g_reg
      p_broadcast_r2: assert property (@(posedge clk) disable iff (rst)
        (!mask_o[p] && op_i == OP_BCAST && rd_i == r)
        |=> (gpr_o[(p*NREG+r)*DW +: DW] == $past(cu_data_i)));
    end
  end
endmodule

bind simd_pe_array simd_pe_array_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .rd_i      (rd_i),
  .gaddr_i   (gaddr_i),
  .cu_data_i (cu_data_i),
  .gpr_o     (gpr_o),
  .mask_o    (mask_o),
  .addr_o    (addr_o),
  .idx_flat  (idx_flat)
);

// File: tb/simd_pe_array_tb.sv
module simd_pe_array_tb;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW   = 16;
  localparam int AW   = 12;
  localparam int NPE  = ROWS * COLS;
  localparam int NR   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]           op_i = '0;
  logic [1:0]           rd_i = '0;
  logic [1:0]           rs_i = '0;
  logic [AW-1:0]        gaddr_i = '0;
  logic [DW-1:0]        cu_data_i = '0;
  logic [NPE*NR*DW-1:0] gpr_o;
  logic [NPE-1:0]       mask_o;
  logic [NPE*AW-1:0]    addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [DW-1:0] m_gpr  [NPE][NR];
  logic [DW-1:0] m_idx  [NPE];
  logic          m_mask [NPE];
  logic [AW-1:0] m_addr [NPE];

  always #10 clk = ~clk;

  simd_pe_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .rd_i(rd_i), .rs_i(rs_i),
    .gaddr_i(gaddr_i), .cu_data_i(cu_data_i),
    .gpr_o(gpr_o), .mask_o(mask_o), .addr_o(addr_o)
  );

  function automatic string req_tag(input logic [3:0] op, input bit any_masked);
    string t;
    case (op)
      4'd1: t = "R2";
      4'd2: t = "R3";
      4'd3: t = "R4";
      4'd4: t = "R9";
      4'd5, 4'd6: t = "R8";
      4'd7: t = "R6";
      4'd8: t = "R7";
      default: t = "R10";
    endcase
    if (any_masked && op >= 4'd1 && op <= 4'd6) t = {t, "+R5"};
    return {t, "/R11"};
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NPE; p++) begin
      for (int r = 0; r < NR; r++) m_gpr[p][r] = '0;
      m_idx[p] = '0; m_mask[p] = 1'b0; m_addr[p] = '0;
    end
  endtask

  task automatic model_step(input logic [3:0] op, input logic [1:0] rd,
                            input logic [1:0] rs, input logic [AW-1:0] ga,
                            input logic [DW-1:0] d);
    for (int p = 0; p < NPE; p++) begin
      logic old_mask;
      logic [DW-1:0] a, b;
      old_mask = m_mask[p];
      a = m_gpr[p][rd];
      b = m_gpr[p][rs];
      if (op == 4'd7) m_mask[p] = b[DW-1];
      if (op == 4'd8) m_mask[p] = 1'b0;
      if (!old_mask) begin
        case (op)
          4'd1: m_gpr[p][rd] = d;
          4'd2: m_gpr[p][rd] = a + b;
          4'd3: m_gpr[p][rd] = a - b;
          4'd4: m_gpr[p][rd] = DW'(p);
          4'd5: m_idx[p] = b;
          4'd6: m_addr[p] = AW'(m_idx[p] + DW'(ga));
          default: ;
        endcase
      end
    end
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    checks++;
    for (int p = 0; p < NPE; p++) begin
      if (mask_o[p] !== m_mask[p]) begin
        bad = 1;
        $display("FAIL %s pe%0d mask got %0b exp %0b", tag, p, mask_o[p], m_mask[p]);
      end
      if (addr_o[p*AW +: AW] !== m_addr[p]) begin
        bad = 1;
        $display("FAIL %s pe%0d addr got %h exp %h", tag, p, addr_o[p*AW +: AW], m_addr[p]);
      end
      for (int r = 0; r < NR; r++) begin
        if (gpr_o[(p*NR+r)*DW +: DW] !== m_gpr[p][r]) begin
          bad = 1;
          $display("FAIL %s pe%0d r%0d got %h exp %h", tag, p, r,
                   gpr_o[(p*NR+r)*DW +: DW], m_gpr[p][r]);
        end
      end
    end
    if (bad) errors++;
  endtask

  // Called at a falling edge: issue, let one rising edge capture, compare at next falling edge.
  task automatic issue(input logic [3:0] op, input logic [1:0] rd, input logic [1:0] rs,
                       input logic [AW-1:0] ga, input logic [DW-1:0] d);
    bit any_m = 0;
    for (int p = 0; p < NPE; p++) if (m_mask[p]) any_m = 1;
    op_i = op; rd_i = rd; rs_i = rs; gaddr_i = ga; cu_data_i = d;
    @(posedge clk);
    model_step(op, rd, rs, ga, d);
    @(negedge clk);
    op_i = 4'd0;
    compare(req_tag(op, any_m));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1");

    // R9: each element loads its own position
    issue(4'd4, 2'd0, 2'd0, '0, '0);
    issue(4'd4, 2'd3, 2'd0, '0, '0);
    // R2: broadcast constant 8
    issue(4'd1, 2'd1, 2'd0, '0, 16'd8);
    // R3 / R4
    issue(4'd2, 2'd0, 2'd1, '0, '0);
    issue(4'd3, 2'd3, 2'd1, '0, '0);     // ids 0..7 go negative
    // R3 wrap: 0x7FFF + 0x7FFF
    issue(4'd1, 2'd2, 2'd0, '0, 16'h7FFF);
    issue(4'd2, 2'd2, 2'd2, '0, '0);
    // R4 wrap: 0 - 1
    issue(4'd1, 2'd2, 2'd0, '0, 16'h0000);
    issue(4'd1, 2'd1, 2'd0, '0, 16'h0001);
    issue(4'd3, 2'd2, 2'd1, '0, '0);
    // R6: mask from sign of r3, R5: masked elements ignore work
    issue(4'd7, 2'd0, 2'd3, '0, '0);
    issue(4'd1, 2'd0, 2'd0, '0, 16'h1234);
    issue(4'd2, 2'd3, 2'd3, '0, '0);
    issue(4'd5, 2'd0, 2'd3, '0, '0);
    // R10: reserved opcodes
    issue(4'd12, 2'd1, 2'd2, 12'hFFF, 16'hBEEF);
    issue(4'd15, 2'd2, 2'd3, 12'h123, 16'hDEAD);
    issue(4'd0, 2'd3, 2'd1, 12'h456, 16'hCAFE);
    // R6: set mask runs in masked elements too (r1 = 1, non-negative -> all clear)
    issue(4'd7, 2'd0, 2'd1, '0, '0);
    // R8: index load and address wrap
    issue(4'd4, 2'd0, 2'd0, '0, '0);
    issue(4'd5, 2'd0, 2'd0, '0, '0);
    issue(4'd6, 2'd0, 2'd0, 12'hFFA, '0);
    // R7: mask everything then clear
    issue(4'd1, 2'd2, 2'd0, '0, 16'h8000);
    issue(4'd7, 2'd0, 2'd2, '0, '0);
    issue(4'd6, 2'd0, 2'd0, 12'h010, '0);
    issue(4'd8, 2'd0, 2'd0, '0, '0);

    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom % 16);
      if (op == 4'd8 && ($urandom % 3) != 0) op = 4'd7;
      issue(op, 2'($urandom), 2'($urandom), AW'($urandom), DW'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule